// File: doc/BRIEF.md
# Converter Start-Up and Fault-Recovery Sequencer

This block is the digital sequencer that brings a synchronous buck converter from power-on to switching and takes it back off when something goes wrong. Once the enable pin is high and the internal 3.3 V supply is good, it walks through a configuration load, a settle wait and a bias check. It then raises a pre-enable and, after a fixed delay, the buck enable that lets the gate drivers switch.

The fault inputs come from analog comparators outside the block. Three of them form the internal group: driver-supply undervoltage, input undervoltage and over-temperature. The external group is the output-undervoltage flag and the current-limit latch. Every comparator input passes through a filter that ignores short pulses on both edges. The output-undervoltage flag has hysteresis: a low-threshold comparator sets it and a high-threshold comparator clears it.

A fault while the converter is pre-enabled or running starts a hiccup: both enables drop for a fixed off time, and the machine then returns to the bias check and retries. The configuration load is a stub that answers its own request after a fixed number of cycles. All waits are counted in clock cycles that are set by parameters.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While `en_pin` or `v3v_good` is low at a clock edge, the sequencer enters the reset phase at that edge from any phase, and both `pre_en` and `buck_en` are 0.
- R2: `seq_state` reports the phase with these codes: 0 reset, 1 config load, 2 settle, 3 bias check, 4 pre-enable, 5 run, 6 hiccup. From reset with both power-up conditions true, the sequencer moves to config load on the next edge. Config load lasts CFG_CYC cycles, then settle lasts SETTLE_CYC cycles, then the bias check follows.
- R3: The bias check holds for as long as the filtered internal fault is set. On the first edge at which it is clear, the sequencer moves to pre-enable.
- R4: Pre-enable lasts exactly PRE_CYC cycles if no fault occurs, then the sequencer moves to run. Run can only be entered from pre-enable.
- R5: `pre_en` is 1 only in pre-enable and run, and `buck_en` is 1 only in run.
- R6: The internal fault is the OR of the filtered driver-supply undervoltage, input undervoltage and over-temperature inputs. A sustained assertion of any one of them in run leads to hiccup.
- R7: The external fault is the OR of the filtered output-undervoltage flag and `ilim_latch`. `ilim_latch` is not filtered: a one-cycle pulse in run moves the sequencer to hiccup at the next edge.
- R8: Any fault in pre-enable or run moves the sequencer to hiccup at the next edge. Hiccup lasts HICCUP_CYC cycles, then the sequencer returns to the bias check.
- R9: A filtered fault takes a new raw level only after DGL_CYC consecutive samples at that level. A pulse of DGL_CYC-1 cycles or shorter, in either direction, has no effect.
- R10: The output-undervoltage flag is set by `out_below_lo` and cleared by `out_above_hi`. It keeps its value while both are low, and set wins if both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Enable pin level |
| v3v_good | input | 1 | Internal 3.3 V rail above its 2.6 V threshold |
| drv_uv_raw | input | 1 | Driver-supply undervoltage comparator |
| vin_uv_raw | input | 1 | Input undervoltage comparator |
| ot_raw | input | 1 | Over-temperature comparator |
| out_below_lo | input | 1 | Output below 80 % of nominal |
| out_above_hi | input | 1 | Output above 90 % of nominal |
| ilim_latch | input | 1 | Current-limit latch from the overcurrent counter |
| pre_en | output | 1 | Pre-enable |
| buck_en | output | 1 | Buck (switching) enable |
| seq_state | output | 3 | Current phase code (see R2) |

## Verification
The assertions assume that every input is synchronous to `clk`, and that `ilim_latch` is already a latched, clean level. They also assume that the two output-threshold comparators behave as a threshold pair, so any overlap resolves to set. The stimulus changes inputs only on falling clock edges. It drives the comparators as levels or pulses of chosen length: pulses shorter than and equal to the filter window, sustained faults in bias check and in run, and a one-cycle current-limit pulse. It also removes the power-up conditions during run and during hiccup. A behavioural model in the bench follows the phase on every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_CFG    = 3'd1,
    PH_SETTLE = 3'd2,
    PH_BIAS   = 3'd3,
    PH_PRE    = 3'd4,
    PH_RUN    = 3'd5,
    PH_HICCUP = 3'd6
  } phase_t;

  localparam int FLT_LANES = 4; // drv, vin, ot, out-uv

endpackage

// File: rtl/seq_deglitch.sv
module seq_deglitch #(
  parameter int DGL_CYC = 4,
  parameter int LANES   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] raw,
  output logic [LANES-1:0] filt
);
  localparam int CW = $clog2(DGL_CYC + 1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run_q   <= '0;
        filt[g] <= 1'b0;
      end else if (raw[g] == filt[g]) begin
        run_q <= '0;
      end else if (run_q == CW'(DGL_CYC - 1)) begin
        run_q   <= '0;
        filt[g] <= raw[g];
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/seq_uv_hyst.sv
module seq_uv_hyst (
  input  logic clk,
  input  logic rst_n,
  input  logic below_lo,
  input  logic above_hi,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (below_lo) flag <= 1'b1;
    else if (above_hi) flag <= 1'b0;
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (cnt_q != '1)  cnt_q <= cnt_q + W'(1);
  end

  assign hit = (cnt_q == (limit - W'(1)));
endmodule

// File: rtl/seq_cfg_stub.sv
module seq_cfg_stub #(
  parameter int CFG_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic done
);
  localparam int CW = $clog2(CFG_CYC + 1);
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(CFG_CYC - 1));
  assign done = req && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!req)  cnt_q <= '0;
    else if (!last) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DGL_CYC    = 11000,
  parameter int CFG_CYC    = 16,
  parameter int SETTLE_CYC = 100000,
  parameter int PRE_CYC    = 10000,
  parameter int HICCUP_CYC = 10000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       v3v_good,
  input  logic       drv_uv_raw,
  input  logic       vin_uv_raw,
  input  logic       ot_raw,
  input  logic       out_below_lo,
  input  logic       out_above_hi,
  input  logic       ilim_latch,
  output logic       pre_en,
  output logic       buck_en,
  output logic [2:0] seq_state
);
  localparam int MAX_A = (SETTLE_CYC > PRE_CYC) ? SETTLE_CYC : PRE_CYC;
  localparam int MAX_C = (MAX_A > HICCUP_CYC) ? MAX_A : HICCUP_CYC;
  localparam int TW    = $clog2(MAX_C + 1);

  phase_t ph_q, ph_nxt;
  logic   puc, uv_flag, fault_int, fault_ext, cfg_done, t_hit;
  logic [FLT_LANES-1:0] raw_vec, filt_vec;
  logic [TW-1:0] t_limit;

  assign puc = en_pin && v3v_good;

  seq_uv_hyst u_hyst (
    .clk(clk), .rst_n(rst_n),
    .below_lo(out_below_lo), .above_hi(out_above_hi), .flag(uv_flag)
  );

  assign raw_vec = {uv_flag, ot_raw, vin_uv_raw, drv_uv_raw};

  seq_deglitch #(.DGL_CYC(DGL_CYC), .LANES(FLT_LANES)) u_dgl (
    .clk(clk), .rst_n(rst_n), .raw(raw_vec), .filt(filt_vec)
  );

  assign fault_int = |filt_vec[2:0];
  assign fault_ext = filt_vec[3] | ilim_latch;

  seq_cfg_stub #(.CFG_CYC(CFG_CYC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .req(ph_q == PH_CFG), .done(cfg_done)
  );

  always_comb begin
    case (ph_q)
      PH_SETTLE: t_limit = TW'(SETTLE_CYC);
      PH_PRE:    t_limit = TW'(PRE_CYC);
      PH_HICCUP: t_limit = TW'(HICCUP_CYC);
      default:   t_limit = TW'(1);
    endcase
  end

  seq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(ph_nxt != ph_q), .limit(t_limit), .hit(t_hit)
  );

  always_comb begin
    ph_nxt = ph_q;
    if (!puc) begin
      ph_nxt = PH_OFF;
    end else begin
      case (ph_q)
        PH_OFF:    ph_nxt = PH_CFG;
        PH_CFG:    if (cfg_done) ph_nxt = PH_SETTLE;
        PH_SETTLE: if (t_hit) ph_nxt = PH_BIAS;
        PH_BIAS:   if (!fault_int) ph_nxt = PH_PRE;
        PH_PRE: begin
          if (fault_int || fault_ext) ph_nxt = PH_HICCUP;
          else if (t_hit)             ph_nxt = PH_RUN;
        end
        PH_RUN:    if (fault_int || fault_ext) ph_nxt = PH_HICCUP;
        PH_HICCUP: if (t_hit) ph_nxt = PH_BIAS;
        default:   ph_nxt = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_OFF;
    else        ph_q <= ph_nxt;
  end

  assign pre_en    = (ph_q == PH_PRE) || (ph_q == PH_RUN);
  assign buck_en   = (ph_q == PH_RUN);
  assign seq_state = ph_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_pin,
  input logic       v3v_good,
  input logic       ilim_latch,
  input logic       pre_en,
  input logic       buck_en,
  input logic [2:0] seq_state
);
  AST_BUCK_NEEDS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    buck_en |-> pre_en); // R5

  AST_PUC_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_pin && v3v_good) |=> (seq_state == 3'd0) && !pre_en && !buck_en); // R1

  AST_ILIM_HICCUP: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd5) && ilim_latch && en_pin && v3v_good |=> seq_state == 3'd6); // R7

  AST_RUN_FROM_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buck_en) |-> $past(seq_state) == 3'd4); // R4

  AST_HICCUP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seq_state) == 3'd6) && (seq_state != 3'd6)
      |-> (seq_state == 3'd3) || (seq_state == 3'd0)); // R8
endmodule

bind pwr_seq_ctrl pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .v3v_good(v3v_good),
  .ilim_latch(ilim_latch), .pre_en(pre_en), .buck_en(buck_en),
  .seq_state(seq_state)
);

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int DGL = 4;
  localparam int CFG = 3;
  localparam int SET = 10;
  localparam int PRE = 6;
  localparam int HIC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, v3v_good = 1'b0;
  logic drv_uv_raw = 1'b0, vin_uv_raw = 1'b0, ot_raw = 1'b0;
  logic out_below_lo = 1'b0, out_above_hi = 1'b0, ilim_latch = 1'b0;
  logic pre_en, buck_en;
  logic [2:0] seq_state;

  int checks = 0;
  int errors = 0;
  bit trace_on = 1'b0;
  string cur_req = "R2";

  always #2 clk = ~clk;

  pwr_seq_ctrl #(.DGL_CYC(DGL), .CFG_CYC(CFG), .SETTLE_CYC(SET),
                 .PRE_CYC(PRE), .HICCUP_CYC(HIC)) dut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .v3v_good(v3v_good),
    .drv_uv_raw(drv_uv_raw), .vin_uv_raw(vin_uv_raw), .ot_raw(ot_raw),
    .out_below_lo(out_below_lo), .out_above_hi(out_above_hi),
    .ilim_latch(ilim_latch), .pre_en(pre_en), .buck_en(buck_en),
    .seq_state(seq_state)
  );

  // behavioural reference
  int m_st = 0, m_cnt = 0;
  bit m_uv = 0;
  bit m_f[4];
  int m_run[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_uv = 0;
      for (int i = 0; i < 4; i++) begin m_f[i] = 0; m_run[i] = 0; end
    end else begin
      bit fi, fe, rw[4];
      int ns;
      fi = m_f[0] | m_f[1] | m_f[2];
      fe = m_f[3] | ilim_latch;
      ns = m_st;
      if (!(en_pin && v3v_good)) ns = 0;
      else case (m_st)
        0: ns = 1;
        1: if (m_cnt == CFG - 1) ns = 2;
        2: if (m_cnt == SET - 1) ns = 3;
        3: if (!fi) ns = 4;
        4: if (fi || fe) ns = 6; else if (m_cnt == PRE - 1) ns = 5;
        5: if (fi || fe) ns = 6;
        6: if (m_cnt == HIC - 1) ns = 3;
        default: ns = 0;
      endcase
      m_cnt = (ns != m_st) ? 0 : m_cnt + 1;
      m_st = ns;
      rw[0] = drv_uv_raw; rw[1] = vin_uv_raw; rw[2] = ot_raw; rw[3] = m_uv;
      for (int i = 0; i < 4; i++) begin
        if (rw[i] == m_f[i]) m_run[i] = 0;
        else begin
          m_run[i]++;
          if (m_run[i] == DGL) begin m_f[i] = rw[i]; m_run[i] = 0; end
        end
      end
      if (out_below_lo) m_uv = 1;
      else if (out_above_hi) m_uv = 0;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (trace_on) begin
      check(cur_req, int'(seq_state), m_st, "trace seq_state");
      check("R5", int'(pre_en), int'(m_st == 4 || m_st == 5), "trace pre_en");
      check("R5", int'(buck_en), int'(m_st == 5), "trace buck_en");
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    step(3);
    check("R1", int'(seq_state), 0, "reset phase");
    check("R1", int'(buck_en), 0, "reset buck_en");
    rst_n = 1'b1;
    step(2);
    trace_on = 1'b1;
    cur_req = "R1";
    check("R1", int'(seq_state), 0, "held off by en low");

    // R2 power-up order
    cur_req = "R2";
    en_pin = 1'b1; v3v_good = 1'b1;
    step(1);  check("R2", int'(seq_state), 1, "config load");
    step(3);  check("R2", int'(seq_state), 2, "settle");
    step(10); check("R3", int'(seq_state), 3, "bias check");
    step(1);  check("R4", int'(seq_state), 4, "pre-enable");
    check("R5", int'(pre_en), 1, "pre_en in pre-enable");
    check("R5", int'(buck_en), 0, "buck_en in pre-enable");
    step(6);  check("R4", int'(seq_state), 5, "run after pre-enable");

    // R9 short over-temperature pulse ignored
    cur_req = "R9";
    ot_raw = 1'b1; step(DGL - 1); ot_raw = 1'b0;
    step(8); check("R9", int'(seq_state), 5, "short pulse ignored");

    // R6 sustained over-temperature
    cur_req = "R6";
    ot_raw = 1'b1; step(DGL);
    check("R9", int'(seq_state), 5, "not yet filtered");
    step(1); check("R6", int'(seq_state), 6, "hiccup on internal fault");
    step(25); check("R3", int'(seq_state), 3, "held in bias check");
    ot_raw = 1'b0;
    cur_req = "R3";
    step(DGL); check("R3", int'(seq_state), 3, "release still filtering");
    step(1); check("R3", int'(seq_state), 4, "leaves bias check");
    step(PRE); check("R4", int'(seq_state), 5, "run again");

    // R7/R8 current-limit pulse
    cur_req = "R8";
    ilim_latch = 1'b1; step(1); ilim_latch = 1'b0;
    check("R7", int'(seq_state), 6, "ilim pulse hiccup");
    check("R8", int'(pre_en), 0, "hiccup pre_en");
    step(HIC - 1); check("R8", int'(seq_state), 6, "hiccup last cycle");
    step(1); check("R8", int'(seq_state), 3, "hiccup returns to bias");
    step(1 + PRE); check("R4", int'(seq_state), 5, "run after retry");

    // R10 output undervoltage hysteresis
    cur_req = "R10";
    out_below_lo = 1'b1; step(1); out_below_lo = 1'b0;
    step(10); check("R10", int'(seq_state), 6, "uv flag held causes hiccup");
    step(40); check("R10", int'(buck_en), 0, "flag held between thresholds");
    out_above_hi = 1'b1; step(1); out_above_hi = 1'b0;
    step(60); check("R10", int'(seq_state), 5, "cleared by high threshold");

    // R6 driver-supply lane, R9 input-UV short pulse
    cur_req = "R9";
    vin_uv_raw = 1'b1; step(DGL - 1); vin_uv_raw = 1'b0;
    step(6); check("R9", int'(seq_state), 5, "short vin pulse ignored");
    cur_req = "R6";
    drv_uv_raw = 1'b1; step(DGL + 1);
    check("R6", int'(seq_state), 6, "drv undervoltage hiccup");
    drv_uv_raw = 1'b0;
    step(45); check("R6", int'(seq_state), 5, "recovered");

    // R1 loss of power-up conditions
    cur_req = "R1";
    v3v_good = 1'b0; step(1);
    check("R1", int'(seq_state), 0, "rail loss in run");
    check("R1", int'(buck_en), 0, "rail loss buck_en");
    v3v_good = 1'b1;
    step(1 + CFG + SET + 1 + PRE); check("R2", int'(seq_state), 5, "restart to run");
    ilim_latch = 1'b1; step(1); ilim_latch = 1'b0;
    en_pin = 1'b0; step(1);
    check("R1", int'(seq_state), 0, "enable low in hiccup");
    en_pin = 1'b1;
    step(1 + CFG + SET + 1 + PRE); check("R2", int'(seq_state), 5, "second restart");

    step(2);
    trace_on = 1'b0;
    finish_run();
  end
endmodule